// File: doc/BRIEF.md
# Doorbell Page Command Decoder

This block sits behind a write-only doorbell window into which every user context has its own 4 KiB page. Software rings a doorbell with a single 32-bit little-endian store. The decoder keeps only the offset inside the page and ignores the page number. It reads flag bits out of the written word and turns them into commands, each tagged with the handle carried in the low bits of that word. A single store can raise more than one command.

One offset targets a queue pair, where it can request a send, a receive, or both. A second offset targets a completion queue, where it can arm notification, optionally for solicited events only, and it can also request a poll. Each command type lands in a small FIFO of its own and leaves the block on a ready/valid output. A store to any other offset is rejected with a one-cycle error pulse and has no other effect. The write port stalls until every command raised by the current store has been placed in its FIFO.

Top module: `db_page_decoder`

## Requirements
- R1: Only address bits [11:0] select the command. Bits [ADDR_W-1:12], the page number, have no effect on which commands are raised or on their handles.
- R2: A store to offset 0x000 raises a send command when data bit 31 is set and a receive command when data bit 30 is set. Both can come from the same store.
- R3: A store to offset 0x004 with data bit 31 set raises an arm command. Its solicited-only output equals data bit 30 of that store.
- R4: A store to offset 0x004 with data bit 29 set raises a poll command, whether or not bit 31 is set.
- R5: The handle of every command equals data bits [23:0]. Bits [28:24] never change a handle.
- R6: A store accepted at any offset other than 0x000 or 0x004 raises no command. It drives `db_err` high for exactly the one cycle after acceptance.
- R7: When one store requests both send and receive, the receive command reaches its output in a later cycle than the send command.
- R8: Each command output holds its valid and payload stable until it is accepted, and it delivers commands in order. `db_wr_ready` stays low while any command of an accepted store is still waiting for FIFO space.
- R9: During and right after reset, `db_wr_ready` is high and `db_err` and every command valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| db_wr_valid | input | 1 | Doorbell store present |
| db_wr_ready | output | 1 | Store accepted in this cycle if valid |
| db_wr_addr | input | ADDR_W | Byte address of the store |
| db_wr_data | input | 32 | Stored word |
| db_err | output | 1 | Unsupported-offset pulse |
| snd_valid | output | 1 | Send command available |
| snd_ready | input | 1 | Send command taken |
| snd_handle | output | HANDLE_W | Queue-pair handle for send |
| rcv_valid | output | 1 | Receive command available |
| rcv_ready | input | 1 | Receive command taken |
| rcv_handle | output | HANDLE_W | Queue-pair handle for receive |
| arm_valid | output | 1 | Arm-notify command available |
| arm_ready | input | 1 | Arm command taken |
| arm_handle | output | HANDLE_W | Completion-queue handle for arm |
| arm_solicited | output | 1 | Arm for solicited events only |
| pol_valid | output | 1 | Poll command available |
| pol_ready | input | 1 | Poll command taken |
| pol_handle | output | HANDLE_W | Completion-queue handle for poll |

## Verification
The bench builds the block with ADDR_W of 32 and HANDLE_W of 24, and with the FIFO depth lowered to 2. The shallow depth means two held-back send commands fill the send FIFO, so a third store reaches the stall path and the bench can watch the write port back-pressure and then drain in order. The full 32-bit address lets stores to pages far above zero show that the page number has no effect.

// File: rtl/db_pkg.sv
// Shared constants and types for the doorbell page decoder.
// Assumes 32-bit doorbell stores. Offsets are in-page byte offsets.
package db_pkg;
    localparam int PAGE_OFS_W = 12;
    localparam logic [PAGE_OFS_W-1:0] QP_OFS = 12'h000;
    localparam logic [PAGE_OFS_W-1:0] CQ_OFS = 12'h004;

    localparam int QP_SEND_BIT = 31;
    localparam int QP_RECV_BIT = 30;
    localparam int CQ_ARM_BIT  = 31;
    localparam int CQ_SOL_BIT  = 30;
    localparam int CQ_POLL_BIT = 29;

    typedef struct packed {
        logic send;
        logic recv;
        logic arm;
        logic sol;
        logic poll;
        logic bad;
    } db_flags_t;
endpackage

// File: rtl/db_decode.sv
// Combinational decode of one doorbell store.
// Looks only at the in-page offset; flags from separate bits share one handle.
module db_decode
    import db_pkg::*;
#(
    parameter int HANDLE_W = 24
) (
    input  logic [PAGE_OFS_W-1:0] ofs,
    input  logic [31:0]           data,
    output db_flags_t             flags,
    output logic [HANDLE_W-1:0]   handle
);
    logic is_qp;
    logic is_cq;
    logic unused_data;

    assign is_qp = (ofs == QP_OFS);
    assign is_cq = (ofs == CQ_OFS);
    assign unused_data = ^data;

    // Pick the command flags that belong to the addressed queue type.
    always_comb begin
        flags      = '0;
        flags.send = is_qp & data[QP_SEND_BIT];
        flags.recv = is_qp & data[QP_RECV_BIT];
        flags.arm  = is_cq & data[CQ_ARM_BIT];
        flags.sol  = is_cq & data[CQ_SOL_BIT];
        flags.poll = is_cq & data[CQ_POLL_BIT];
        flags.bad  = ~(is_qp | is_cq);
    end

    assign handle = data[HANDLE_W-1:0];
endmodule

// File: rtl/db_cmd_fifo.sv
// Small synchronous FIFO carrying one command type.
// Assumes DEPTH >= 2. Push is ignored when full; the data memory has no reset.
module db_cmd_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign full      = (count == CW'(DEPTH));
    assign out_valid = (count != '0);
    assign dout      = mem[rd_ptr];
    assign do_push   = push & ~full;
    assign do_pop    = out_valid & out_ready;

    // Store an entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/db_issue.sv
// Holds the commands of one accepted store and hands them to the FIFOs.
// Stalls the write port until all of them are placed; receive waits for send.
module db_issue
    import db_pkg::*;
#(
    parameter int HANDLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  db_flags_t           flags,
    input  logic [HANDLE_W-1:0] handle,
    input  logic                snd_space,
    input  logic                rcv_space,
    input  logic                arm_space,
    input  logic                pol_space,
    output logic                snd_push,
    output logic                rcv_push,
    output logic                arm_push,
    output logic                pol_push,
    output logic [HANDLE_W-1:0] handle_q,
    output logic                sol_q,
    output logic                err
);
    logic pend_snd;
    logic pend_rcv;
    logic pend_arm;
    logic pend_pol;
    logic accept;

    assign wr_ready = ~(pend_snd | pend_rcv | pend_arm | pend_pol);
    assign accept   = wr_valid & wr_ready;

    assign snd_push = pend_snd & snd_space;
    assign rcv_push = pend_rcv & ~pend_snd & rcv_space;
    assign arm_push = pend_arm & arm_space;
    assign pol_push = pend_pol & pol_space;

    // Latch a new store or retire the commands placed this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_snd <= 1'b0;
            pend_rcv <= 1'b0;
            pend_arm <= 1'b0;
            pend_pol <= 1'b0;
            handle_q <= '0;
            sol_q    <= 1'b0;
            err      <= 1'b0;
        end else begin
            err <= accept & flags.bad;
            if (accept) begin
                pend_snd <= flags.send;
                pend_rcv <= flags.recv;
                pend_arm <= flags.arm;
                pend_pol <= flags.poll;
                handle_q <= handle;
                sol_q    <= flags.sol;
            end else begin
                if (snd_push) pend_snd <= 1'b0;
                if (rcv_push) pend_rcv <= 1'b0;
                if (arm_push) pend_arm <= 1'b0;
                if (pol_push) pend_pol <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/db_page_decoder.sv
// Doorbell page command decoder: decode, issue stage, one FIFO per command.
// Assumes one 32-bit store per cycle at most; write-only, no read path.
module db_page_decoder
    import db_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HANDLE_W   = 24,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                db_wr_valid,
    output logic                db_wr_ready,
    input  logic [ADDR_W-1:0]   db_wr_addr,
    input  logic [31:0]         db_wr_data,
    output logic                db_err,
    output logic                snd_valid,
    input  logic                snd_ready,
    output logic [HANDLE_W-1:0] snd_handle,
    output logic                rcv_valid,
    input  logic                rcv_ready,
    output logic [HANDLE_W-1:0] rcv_handle,
    output logic                arm_valid,
    input  logic                arm_ready,
    output logic [HANDLE_W-1:0] arm_handle,
    output logic                arm_solicited,
    output logic                pol_valid,
    input  logic                pol_ready,
    output logic [HANDLE_W-1:0] pol_handle
);
    db_flags_t           flags;
    logic [HANDLE_W-1:0] dec_handle;
    logic [HANDLE_W-1:0] handle_q;
    logic                sol_q;
    logic                snd_push, rcv_push, arm_push, pol_push;
    logic                snd_full, rcv_full, arm_full, pol_full;
    logic                unused_page;

    assign unused_page = ^db_wr_addr;

    db_decode #(.HANDLE_W(HANDLE_W)) i_decode (
        .ofs    (db_wr_addr[PAGE_OFS_W-1:0]),
        .data   (db_wr_data),
        .flags  (flags),
        .handle (dec_handle)
    );

    db_issue #(.HANDLE_W(HANDLE_W)) i_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (db_wr_valid),
        .wr_ready  (db_wr_ready),
        .flags     (flags),
        .handle    (dec_handle),
        .snd_space (~snd_full),
        .rcv_space (~rcv_full),
        .arm_space (~arm_full),
        .pol_space (~pol_full),
        .snd_push  (snd_push),
        .rcv_push  (rcv_push),
        .arm_push  (arm_push),
        .pol_push  (pol_push),
        .handle_q  (handle_q),
        .sol_q     (sol_q),
        .err       (db_err)
    );

    db_cmd_fifo #(.W(HANDLE_W), .DEPTH(FIFO_DEPTH)) i_snd_fifo (
        .clk(clk), .rst_n(rst_n), .push(snd_push), .din(handle_q), .full(snd_full),
        .out_valid(snd_valid), .out_ready(snd_ready), .dout(snd_handle)
    );

    db_cmd_fifo #(.W(HANDLE_W), .DEPTH(FIFO_DEPTH)) i_rcv_fifo (
        .clk(clk), .rst_n(rst_n), .push(rcv_push), .din(handle_q), .full(rcv_full),
        .out_valid(rcv_valid), .out_ready(rcv_ready), .dout(rcv_handle)
    );

    db_cmd_fifo #(.W(HANDLE_W + 1), .DEPTH(FIFO_DEPTH)) i_arm_fifo (
        .clk(clk), .rst_n(rst_n), .push(arm_push), .din({sol_q, handle_q}), .full(arm_full),
        .out_valid(arm_valid), .out_ready(arm_ready), .dout({arm_solicited, arm_handle})
    );

    db_cmd_fifo #(.W(HANDLE_W), .DEPTH(FIFO_DEPTH)) i_pol_fifo (
        .clk(clk), .rst_n(rst_n), .push(pol_push), .din(handle_q), .full(pol_full),
        .out_valid(pol_valid), .out_ready(pol_ready), .dout(pol_handle)
    );
endmodule

// File: rtl/db_page_decoder_chk.sv
// Property checker for the doorbell page decoder, attached by bind.
// Watches the ports only.
module db_page_decoder_chk #(
    parameter int HANDLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic                wr_ready,
    input logic [11:0]         wr_ofs,
    input logic [1:0]          top_bits,
    input logic                err,
    input logic                snd_valid,
    input logic                snd_ready,
    input logic [HANDLE_W-1:0] snd_handle,
    input logic                arm_valid,
    input logic                arm_ready,
    input logic [HANDLE_W-1:0] arm_handle
);
    // R6
    bad_ofs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_ofs != 12'h000 && wr_ofs != 12'h004) |=> err);

    // R6
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_valid && wr_ready));

    // R8
    snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_handle)));

    // R8
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_valid && !arm_ready) |=> (arm_valid && $stable(arm_handle)));

    // R7
    pair_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_ofs == 12'h000 && top_bits == 2'b11) |=> !wr_ready);
endmodule

bind db_page_decoder db_page_decoder_chk #(.HANDLE_W(HANDLE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (db_wr_valid),
    .wr_ready   (db_wr_ready),
    .wr_ofs     (db_wr_addr[11:0]),
    .top_bits   (db_wr_data[31:30]),
    .err        (db_err),
    .snd_valid  (snd_valid),
    .snd_ready  (snd_ready),
    .snd_handle (snd_handle),
    .arm_valid  (arm_valid),
    .arm_ready  (arm_ready),
    .arm_handle (arm_handle)
);

// File: tb/test_db_page_decoder.sv
// Directed bench for the doorbell page decoder: one task per scenario.
module test_db_page_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam int HW         = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [31:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          err;
    logic          snd_valid, rcv_valid, arm_valid, pol_valid;
    logic          snd_ready = 1'b1, rcv_ready = 1'b1, arm_ready = 1'b1, pol_ready = 1'b1;
    logic [HW-1:0] snd_handle, rcv_handle, arm_handle, pol_handle;
    logic          arm_sol;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int snd_n, rcv_n, arm_n, pol_n, err_n;
    int snd_h [16];
    int snd_t [16];
    int rcv_h [16];
    int rcv_t [16];
    int arm_h [16];
    int arm_s [16];
    int pol_h [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    db_page_decoder #(.ADDR_W(32), .HANDLE_W(HW), .FIFO_DEPTH(DEPTH)) i_db_page_decoder (
        .clk(clk), .rst_n(rst_n),
        .db_wr_valid(wr_valid), .db_wr_ready(wr_ready),
        .db_wr_addr(wr_addr), .db_wr_data(wr_data), .db_err(err),
        .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_handle(snd_handle),
        .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_handle(rcv_handle),
        .arm_valid(arm_valid), .arm_ready(arm_ready), .arm_handle(arm_handle),
        .arm_solicited(arm_sol),
        .pol_valid(pol_valid), .pol_ready(pol_ready), .pol_handle(pol_handle)
    );

    // Record every accepted command and every error cycle.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (snd_valid && snd_ready && snd_n < 16) begin
                snd_h[snd_n] = int'(snd_handle); snd_t[snd_n] = cyc; snd_n = snd_n + 1;
            end
            if (rcv_valid && rcv_ready && rcv_n < 16) begin
                rcv_h[rcv_n] = int'(rcv_handle); rcv_t[rcv_n] = cyc; rcv_n = rcv_n + 1;
            end
            if (arm_valid && arm_ready && arm_n < 16) begin
                arm_h[arm_n] = int'(arm_handle); arm_s[arm_n] = int'(arm_sol); arm_n = arm_n + 1;
            end
            if (pol_valid && pol_ready && pol_n < 16) begin
                pol_h[pol_n] = int'(pol_handle); pol_n = pol_n + 1;
            end
            if (err) err_n = err_n + 1;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        snd_n = 0; rcv_n = 0; arm_n = 0; pol_n = 0; err_n = 0;
    endtask

    task automatic do_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", "wr_ready", int'(wr_ready), 1);
        check("R9", "err", int'(err), 0);
        check("R9", "any valid", int'(snd_valid | rcv_valid | arm_valid | pol_valid), 0);
    endtask

    task automatic t_qp_send();
        clear_logs();
        do_write(32'h0005_3000, 32'h8012_3456);
        settle(4);
        check("R1", "send count high page", snd_n, 1);
        check("R2", "send handle", snd_h[0], 32'h12_3456);
        check("R2", "recv count", rcv_n, 0);
    endtask

    task automatic t_qp_recv();
        clear_logs();
        do_write(32'h0000_9000, 32'h4000_0011);
        settle(4);
        check("R2", "recv count", rcv_n, 1);
        check("R2", "recv handle", rcv_h[0], 32'h11);
        check("R2", "send count", snd_n, 0);
    endtask

    task automatic t_qp_both();
        clear_logs();
        do_write(32'h0000_7000, 32'hC0AB_CDEF);
        settle(5);
        check("R2", "both send count", snd_n, 1);
        check("R2", "both recv count", rcv_n, 1);
        check("R2", "both recv handle", rcv_h[0], 32'hAB_CDEF);
        check("R7", "send before recv", int'(snd_t[0] < rcv_t[0]), 1);
    endtask

    task automatic t_cq_arm();
        clear_logs();
        do_write(32'h1234_5004, 32'hC000_0077);
        do_write(32'hFFFF_F004, 32'h8000_0078);
        settle(4);
        check("R3", "arm count", arm_n, 2);
        check("R3", "arm handle solicited", arm_h[0], 32'h77);
        check("R3", "solicited set", arm_s[0], 1);
        check("R1", "arm handle top page", arm_h[1], 32'h78);
        check("R3", "solicited clear", arm_s[1], 0);
        check("R4", "no poll", pol_n, 0);
    endtask

    task automatic t_cq_poll();
        clear_logs();
        do_write(32'h0000_2004, 32'h2000_0099);
        do_write(32'h0000_3004, 32'hA000_00AA);
        settle(4);
        check("R4", "poll count", pol_n, 2);
        check("R4", "poll alone handle", pol_h[0], 32'h99);
        check("R4", "poll with arm handle", pol_h[1], 32'hAA);
        check("R4", "arm count", arm_n, 1);
    endtask

    task automatic t_mask();
        clear_logs();
        do_write(32'h0000_0000, 32'h9F00_0042);
        do_write(32'h0000_0004, 32'h3E00_0043);
        settle(4);
        check("R5", "send handle masked", snd_h[0], 32'h42);
        check("R5", "poll handle masked", pol_h[0], 32'h43);
    endtask

    task automatic t_bad();
        clear_logs();
        do_write(32'h0000_0008, 32'hFFFF_FFFF);
        settle(3);
        check("R6", "err pulses", err_n, 1);
        check("R6", "commands", snd_n + rcv_n + arm_n + pol_n, 0);
        do_write(32'h0000_1001, 32'hE000_0001);
        settle(3);
        check("R6", "err pulses unaligned", err_n, 2);
        check("R6", "commands unaligned", snd_n + rcv_n + arm_n + pol_n, 0);
        check("R6", "wr_ready after error", int'(wr_ready), 1);
    endtask

    task automatic t_stall();
        clear_logs();
        snd_ready = 1'b0;
        do_write(32'h0000_0000, 32'h8000_0001);
        do_write(32'h0000_0000, 32'h8000_0002);
        do_write(32'h0000_0000, 32'h8000_0003);
        settle(3);
        check("R8", "stalled wr_ready", int'(wr_ready), 0);
        check("R8", "head valid", int'(snd_valid), 1);
        check("R8", "head handle held", int'(snd_handle), 1);
        snd_ready = 1'b1;
        settle(6);
        check("R8", "drained count", snd_n, 3);
        check("R8", "order 0", snd_h[0], 1);
        check("R8", "order 1", snd_h[1], 2);
        check("R8", "order 2", snd_h[2], 3);
        check("R8", "wr_ready after drain", int'(wr_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_logs();
        settle(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_qp_send();
        t_qp_recv();
        t_qp_both();
        t_cq_arm();
        t_cq_poll();
        t_mask();
        t_bad();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule